// File: doc/BRIEF.md
# Unlock Address Sequence Detector

This block sits beside a memory port and observes every access that port completes. It arms a nonvolatile transfer only when software reads a fixed series of five key addresses in strict order, followed by a sixth read whose address picks the command. One final address asks for a copy of the working array into the backing store. A different final address asks for the reverse copy.

Anything else cancels the partly entered series, and no command is issued. This covers a write, a read off the expected path, a repeated read of the same location, and a reserved final address. The one exception is a cancelling read of the first key address: it is taken as a fresh start, so the detector stands at one matched key afterwards.

While the transfer controller reports that it is busy, every access is disregarded and the detector is kept at rest. The command pulses feed that controller. The step index is brought out so a monitor can follow the progress of the series.

Top module: `knock_seq_detect`

## Requirements
- R1: During and after reset (rst_n low), step_idx is 0 and both store_req and recall_req are low.
- R2: The prefix keys are, in this order, 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F. Each counted read (acc_vld high, acc_wr low) of the next expected key raises step_idx by one, from 0 up to 5. The new value is visible after the clock edge that samples the access.
- R3: At step_idx 5, a counted read of 0x0FC0 makes store_req high for exactly the one cycle after that edge, with recall_req low, and step_idx returns to 0.
- R4: At step_idx 5, a counted read of 0x0C63 makes recall_req high for exactly one cycle, with store_req low, and step_idx returns to 0.
- R5: Only acc_addr[13:0] is compared. The value of acc_addr[14] never changes the result of an access.
- R6: A counted write (acc_vld and acc_wr high) at any step returns step_idx to 0 and issues no request, whatever its address.
- R7: A counted read of an address other than the next expected key returns step_idx to 0 and issues no request.
- R8: Two consecutive counted reads of the same key address cancel the series. The second read is treated as an off-path read.
- R9: At step_idx 5, a read of the reserved address 0x339C issues no request and returns step_idx to 0.
- R10: A read of 0x0E38 that cancels a series leaves step_idx at 1, not 0.
- R11: In every cycle where xfer_busy is high, step_idx becomes 0 and no request is issued. Accesses presented in those cycles have no effect.
- R12: Cycles with acc_vld low leave step_idx unchanged and issue no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | One-cycle strobe: an enabled access completes this cycle |
| acc_wr | input | 1 | Access is a write (1) or a read (0) |
| acc_addr | input | 15 | Access address |
| xfer_busy | input | 1 | Transfer controller is busy |
| store_req | output | 1 | One-cycle request to copy the array to the backing store |
| recall_req | output | 1 | One-cycle request to copy the backing store into the array |
| step_idx | output | 3 | Number of prefix keys matched so far (0 to 5) |

## Verification
The bench goes after the places where a matching engine tends to slip.

- A repeated key read: a detector that tolerated it would still fire after a noisy enable.
- A cancelling read of the first key: getting this wrong leaves the detector at 0 instead of 1, so a series entered right after a stray read fails.
- The reserved final address: a detector that treats it as a store would copy data unasked.
- Bit 14 set on otherwise valid keys: a detector that compared all 15 bits would refuse these.
- Writes and busy cycles in the middle of a series: a detector that ignored the write flag, or kept counting while busy, would issue a request the software never completed.

// File: rtl/knock_pkg.sv
package knock_pkg;
  localparam int KEY_W      = 14;
  localparam int PREFIX_LEN = 5;
  localparam int N_KEYS     = PREFIX_LEN + 2;
  localparam int IDX_STORE  = PREFIX_LEN;
  localparam int IDX_RECALL = PREFIX_LEN + 1;

  function automatic logic [KEY_W-1:0] key_at(input int idx);
    case (idx)
      0:       key_at = 14'h0E38;
      1:       key_at = 14'h31C7;
      2:       key_at = 14'h03E0;
      3:       key_at = 14'h3C1F;
      4:       key_at = 14'h303F;
      5:       key_at = 14'h0FC0;
      6:       key_at = 14'h0C63;
      default: key_at = '0;
    endcase
  endfunction
endpackage

// File: rtl/knock_key_match.sv
module knock_key_match
  import knock_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_KEYS-1:0] hit
);
  logic [KEY_W-1:0] addr_low;
  assign addr_low = addr[KEY_W-1:0];

  for (genvar g = 0; g < N_KEYS; g++) begin : g_cmp
    assign hit[g] = (addr_low == key_at(g));
  end

  always_comb begin
    a_r5_hit_onehot : assert ($onehot0(hit));
  end
endmodule

// File: rtl/knock_step_fsm.sv
module knock_step_fsm
  import knock_pkg::*;
#(
  parameter int STEP_W = $clog2(PREFIX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic              busy,
  input  logic [N_KEYS-1:0] hit,
  output logic [STEP_W-1:0] step,
  output logic              fire_store,
  output logic              fire_recall
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);
  localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_nxt;
  logic              take;
  logic              step_en;
  logic              restart;

  assign take    = acc_vld && !busy;
  assign step_en = take || busy;
  assign restart = hit[0];

  always_comb begin
    step_nxt    = step_q;
    fire_store  = 1'b0;
    fire_recall = 1'b0;
    if (busy) begin
      step_nxt = '0;
    end else if (take) begin
      if (acc_wr) begin
        step_nxt = '0;
      end else if (step_q == LAST_STEP) begin
        if (hit[IDX_STORE]) begin
          fire_store = 1'b1;
          step_nxt   = '0;
        end else if (hit[IDX_RECALL]) begin
          fire_recall = 1'b1;
          step_nxt    = '0;
        end else begin
          step_nxt = restart ? ONE_STEP : '0;
        end
      end else if (hit[step_q]) begin
        step_nxt = step_q + ONE_STEP;
      end else begin
        step_nxt = restart ? ONE_STEP : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_nxt;
    end
  end

  assign step = step_q;

  a_r2_step_range : assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);
  a_r6_write_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wr) |=> (step_q == '0));
  a_r12_idle_holds : assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_vld && !busy) |=> $stable(step_q));
  a_r2_step_by_one : assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != $past(step_q)) |-> (step_q == $past(step_q) + ONE_STEP
                                   || step_q == '0 || step_q == ONE_STEP));
endmodule

// File: rtl/knock_cmd_reg.sv
module knock_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_store,
  input  logic fire_recall,
  output logic store_req,
  output logic recall_req
);
  logic store_nxt;
  logic recall_nxt;

  always_comb begin
    store_nxt  = fire_store;
    recall_nxt = fire_recall && !fire_store;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= store_nxt;
      recall_req <= recall_nxt;
    end
  end

  a_r3_req_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  a_r3_store_single : assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  a_r4_recall_single : assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
endmodule

// File: rtl/knock_seq_detect.sv
module knock_seq_detect
  import knock_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int STEP_W = $clog2(PREFIX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              xfer_busy,
  output logic              store_req,
  output logic              recall_req,
  output logic [STEP_W-1:0] step_idx
);
  logic [N_KEYS-1:0] hit;
  logic              fire_store;
  logic              fire_recall;

  knock_key_match #(.ADDR_W(ADDR_W)) u_match (
    .addr (acc_addr),
    .hit  (hit)
  );

  knock_step_fsm #(.STEP_W(STEP_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_vld     (acc_vld),
    .acc_wr      (acc_wr),
    .busy        (xfer_busy),
    .hit         (hit),
    .step        (step_idx),
    .fire_store  (fire_store),
    .fire_recall (fire_recall)
  );

  knock_cmd_reg u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_store  (fire_store),
    .fire_recall (fire_recall),
    .store_req   (store_req),
    .recall_req  (recall_req)
  );

  a_r11_busy_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> (step_idx == '0 && !store_req && !recall_req));
  a_r3_req_needs_read : assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> $past(acc_vld && !acc_wr && !xfer_busy
                                        && step_idx == STEP_W'(PREFIX_LEN)));
endmodule

// File: tb/knock_seq_detect_test.sv
module knock_seq_detect_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_vld;
  logic        acc_wr;
  logic [14:0] acc_addr;
  logic        xfer_busy;
  logic        store_req;
  logic        recall_req;
  logic [2:0]  step_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  knock_seq_detect uut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .xfer_busy(xfer_busy), .store_req(store_req),
    .recall_req(recall_req), .step_idx(step_idx)
  );

  localparam logic [14:0] K0 = 15'h0E38, K1 = 15'h31C7, K2 = 15'h03E0,
                          K3 = 15'h3C1F, K4 = 15'h303F, KS = 15'h0FC0,
                          KR = 15'h0C63, KX = 15'h339C;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [14:0] a);
    @(negedge clk);
    acc_vld  = 1'b1;
    acc_wr   = wr;
    acc_addr = a;
    @(posedge clk);
    #1;
    acc_vld = 1'b0;
    acc_wr  = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a);
    access(1'b0, a);
  endtask

  task automatic prefix(input string req, input logic [14:0] hi);
    rd(K0 | hi); check(req, step_idx, 1);
    rd(K1 | hi); check(req, step_idx, 2);
    rd(K2 | hi); check(req, step_idx, 3);
    rd(K3 | hi); check(req, step_idx, 4);
    rd(K4 | hi); check(req, step_idx, 5);
  endtask

  task automatic reqs(input string req, input int es, input int er);
    check({req, " store"}, store_req, es);
    check({req, " recall"}, recall_req, er);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; acc_vld = 1'b0; acc_wr = 1'b0; acc_addr = '0; xfer_busy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 step", step_idx, 0);
    reqs("R1", 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", step_idx, 0);
  endtask

  task automatic t_store;
    prefix("R2", 15'h0);
    rd(KS);
    reqs("R3", 1, 0);
    check("R3 step", step_idx, 0);
    @(posedge clk); #1;
    reqs("R3 one cycle", 0, 0);
  endtask

  task automatic t_recall;
    prefix("R2", 15'h0);
    rd(KR);
    reqs("R4", 0, 1);
    check("R4 step", step_idx, 0);
    @(posedge clk); #1;
    reqs("R4 one cycle", 0, 0);
  endtask

  task automatic t_bit14;
    prefix("R5", 15'h4000);
    rd(KS | 15'h4000);
    reqs("R5", 1, 0);
  endtask

  task automatic t_write;
    rd(K0); rd(K1); rd(K2);
    access(1'b1, K3);
    check("R6 step", step_idx, 0);
    reqs("R6", 0, 0);
    prefix("R6 pre", 15'h0);
    access(1'b1, KS);
    reqs("R6 last", 0, 0);
    check("R6 last step", step_idx, 0);
  endtask

  task automatic t_wrong;
    rd(K0); rd(K1);
    rd(K3);
    check("R7 step", step_idx, 0);
    rd(15'h0123);
    check("R7 idle read", step_idx, 0);
    rd(K1);
    check("R7 K1 from idle", step_idx, 0);
  endtask

  task automatic t_dup;
    rd(K0); rd(K1); rd(K1);
    check("R8 step", step_idx, 0);
    rd(K2);
    check("R8 no resume", step_idx, 0);
  endtask

  task automatic t_reserved;
    prefix("R9 pre", 15'h0);
    rd(KX);
    reqs("R9", 0, 0);
    check("R9 step", step_idx, 0);
  endtask

  task automatic t_restart;
    rd(K0); rd(K1); rd(K2);
    rd(K0);
    check("R10 mid", step_idx, 1);
    rd(K1); rd(K2); rd(K3); rd(K4);
    rd(K0);
    check("R10 at last", step_idx, 1);
    reqs("R10", 0, 0);
    rd(K1); rd(K2); rd(K3); rd(K4); rd(KR);
    reqs("R10 resumed", 0, 1);
  endtask

  task automatic t_idle;
    rd(K0); rd(K1);
    @(negedge clk); acc_addr = K3; acc_wr = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R12 step", step_idx, 2);
    reqs("R12", 0, 0);
    acc_wr = 1'b0;
    rd(K2); rd(K3); rd(K4); rd(KS);
    reqs("R12 finish", 1, 0);
  endtask

  task automatic t_busy;
    rd(K0); rd(K1); rd(K2);
    @(negedge clk); xfer_busy = 1'b1;
    @(posedge clk); #1;
    check("R11 clear", step_idx, 0);
    rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(KS);
    check("R11 step", step_idx, 0);
    reqs("R11", 0, 0);
    @(negedge clk); xfer_busy = 1'b0;
    rd(K1);
    check("R11 after", step_idx, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_store;
    t_recall;
    t_bit14;
    t_write;
    t_wrong;
    t_dup;
    t_reserved;
    t_restart;
    t_idle;
    t_busy;
    repeat (2) @(posedge clk);
    finish_run;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run;
  end
endmodule